// File: doc/BRIEF.md
# Signed High-Word Multiply-Accumulate Unit

This execution unit carries out three related instruction forms. Each one works on two signed 32-bit multiplicands and keeps only the most significant 32 bits of the 64-bit result. The plain form returns the high word of the product. The accumulate form first adds an accumulator word placed in the upper half of a 64-bit value. The subtract form returns that upper-half accumulator minus the product. Any of the three forms can round to nearest: the unit adds 2^31 to the 64-bit intermediate before it takes the high word.

The unit holds its own 16-entry by 32-bit register file. It decodes the register indices and the mode bits straight from the 32-bit instruction word. A one-cycle start pulse in the idle state launches an operation. The unit captures every operand in that cycle. It multiplies in the next cycle and combines, rounds and writes back in the cycle after that. A done pulse then marks that the destination register holds the result. A separate test write port and test read port let a testbench load operands and read back results.

Top module: `mmw_exec_unit`

## Requirements
- R1: A synchronous active-low reset clears all 16 registers to zero and drives both done and busy low.
- R2: The register indices come from these instruction bits: destination 19:16, accumulator 15:12, first multiplicand 11:8, second multiplicand 3:0. Bit 6 selects subtract and bit 5 selects rounding.
- R3: When the accumulator index is 15, the destination receives bits 63:32 of the signed 64-bit product of the two multiplicands.
- R4: When the accumulator index is not 15 and bit 6 is 0, the destination receives bits 63:32 of (accumulator << 32) + product.
- R5: When the accumulator index is not 15 and bit 6 is 1, the destination receives bits 63:32 of (accumulator << 32) - product.
- R6: When bit 5 is 1, the unit adds 0x80000000 to the 64-bit intermediate before it takes the high word.
- R7: All 64-bit arithmetic wraps modulo 2^64.
- R8: Suppose a start is sampled at clock edge k. The write-back then lands at edge k+2, and done is high for exactly the one cycle that follows edge k+2.
- R9: The unit ignores a start while busy. That start writes no register and produces no extra done pulse.
- R10: When the destination index equals a source index, the computation uses the source values held before the write-back.
- R11: With accumulator index 15, bit 6 has no effect and the result is the plain product form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch pulse, honoured only when idle |
| instr_i | input | 32 | Instruction word sampled with start_i |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle pulse after write-back |
| tb_we_i | input | 1 | Test port write enable |
| tb_waddr_i | input | 4 | Test port write index |
| tb_wdata_i | input | 32 | Test port write data |
| tb_raddr_i | input | 4 | Test port read index |
| tb_rdata_o | output | 32 | Test port read data (combinational) |

## Verification
Assertions check several things on every cycle:
- done is a single-cycle pulse that always follows the combine cycle.
- An accepted start always raises busy.
- No write-back happens while the unit is idle.
- The sign of every nonzero product matches the signs of its operands.

Only the bench scenarios can show that each form, the rounding, the wrap-around and the aliased destination give the exact high word. They also show that a start arriving mid-operation leaves the register file untouched.

// File: rtl/mmw_pkg.sv
// Package: shared widths, instruction field positions and state encoding for
// the signed high-word multiply-accumulate unit. Assumes a 32-bit word and a
// 16-entry register file; the field positions are fixed by the instruction format.
package mmw_pkg;
    parameter int DATA_W  = 32;
    parameter int REG_CNT = 16;
    localparam int IDX_W  = $clog2(REG_CNT);
    localparam int PROD_W = 2 * DATA_W;

    // Field positions (LSB of each 4-bit index field)
    localparam int RD_LSB  = 16;
    localparam int RA_LSB  = 12;
    localparam int RM_LSB  = 8;
    localparam int RN_LSB  = 0;
    localparam int SUB_BIT = 6;
    localparam int RND_BIT = 5;

    // Accumulator index meaning "no accumulator"
    localparam logic [IDX_W-1:0] NO_ACC_IDX = IDX_W'(REG_CNT - 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_CMB  = 2'd2
    } mmw_state_t;

    typedef struct packed {
        logic [IDX_W-1:0] dst;
        logic             acc_en;
        logic             sub;
        logic             rnd;
    } mmw_ctrl_t;
endpackage

// File: rtl/mmw_regfile.sv
// Module: register file with NRD combinational operand read ports, one
// combinational test read port, a write-back port and a test write port.
// Assumes write-back and test write never target the same cycle in normal use;
// if they do, write-back wins. Synchronous active-low reset clears every entry.
module mmw_regfile #(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 16,
    parameter int NRD     = 3,
    localparam int IDX_W  = $clog2(REG_CNT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NRD-1:0][IDX_W-1:0] rd_addr,
    output logic [NRD-1:0][DATA_W-1:0] rd_data,
    input  logic                      wb_en,
    input  logic [IDX_W-1:0]          wb_addr,
    input  logic [DATA_W-1:0]         wb_data,
    input  logic                      tw_en,
    input  logic [IDX_W-1:0]          tw_addr,
    input  logic [DATA_W-1:0]         tw_data,
    input  logic [IDX_W-1:0]          tr_addr,
    output logic [DATA_W-1:0]         tr_data
);
    logic [DATA_W-1:0] regs [REG_CNT];

    for (genvar e = 0; e < REG_CNT; e++) begin : g_entry
        // Per-entry storage: reset, then write-back over test write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[e] <= '0;
            end else if (wb_en && wb_addr == IDX_W'(e)) begin
                regs[e] <= wb_data;
            end else if (tw_en && tw_addr == IDX_W'(e)) begin
                regs[e] <= tw_data;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Operand read port p
        always_comb rd_data[p] = regs[rd_addr[p]];
    end

    // Test read port
    always_comb tr_data = regs[tr_addr];
endmodule

// File: rtl/mmw_mul_stage.sv
// Module: registered signed multiplier. Sign-extends both operands and
// registers the full-width product when en is high; holds it otherwise.
module mmw_mul_stage #(
    parameter int DATA_W = 32,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [PROD_W-1:0] prod
);
    logic signed [PROD_W-1:0] ext_a, ext_b;

    // Sign-extend both operands to product width
    always_comb begin
        ext_a = PROD_W'($signed(op_a));
        ext_b = PROD_W'($signed(op_b));
    end

    // Product register
    always_ff @(posedge clk) begin
        if (!rst_n) prod <= '0;
        else if (en) prod <= ext_a * ext_b;
    end

    AST_PROD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_a != '0 && op_b != '0) |=> (prod[PROD_W-1] == ($past(op_a[DATA_W-1]) ^ $past(op_b[DATA_W-1])))); // R3
endmodule

// File: rtl/mmw_combine.sv
// Module: combinational combine/round stage. Places the accumulator in the
// upper half, adds or subtracts the product (accumulator minus product),
// optionally adds the half-LSB rounding constant and returns the high word.
// All arithmetic wraps at the product width.
module mmw_combine #(
    parameter int DATA_W = 32,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic [PROD_W-1:0] prod,
    input  logic [DATA_W-1:0] acc,
    input  logic              acc_en,
    input  logic              sub,
    input  logic              rnd,
    output logic [DATA_W-1:0] hi
);
    localparam logic [PROD_W-1:0] RND_K = PROD_W'(1) << (DATA_W - 1);

    logic [PROD_W-1:0] acc_up, mixed, rounded;

    // Select the form, add rounding, take the upper word
    always_comb begin
        acc_up = {acc, {DATA_W{1'b0}}};
        if (!acc_en)  mixed = prod;
        else if (sub) mixed = acc_up - prod;
        else          mixed = acc_up + prod;
        rounded = rnd ? mixed + RND_K : mixed;
        hi      = rounded[PROD_W-1:DATA_W];
    end
endmodule

// File: rtl/mmw_exec_unit.sv
// Module: top of the signed high-word multiply-accumulate unit. Accepts an
// instruction on start_i while idle, captures all operands that cycle, multiplies
// next cycle, then combines/rounds and writes back, pulsing done_o afterwards.
// Assumes start_i is a pulse; starts while busy are ignored.
module mmw_exec_unit
    import mmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       instr_i,
    output logic              busy_o,
    output logic              done_o,
    input  logic              tb_we_i,
    input  logic [3:0]        tb_waddr_i,
    input  logic [31:0]       tb_wdata_i,
    input  logic [3:0]        tb_raddr_i,
    output logic [31:0]       tb_rdata_o
);
    localparam int NRD = 3;

    mmw_state_t               state;
    mmw_ctrl_t                ctrl_q;
    logic [DATA_W-1:0]        op_a_q, op_b_q, acc_q;
    logic [NRD-1:0][IDX_W-1:0]  rd_addr;
    logic [NRD-1:0][DATA_W-1:0] rd_data;
    logic [PROD_W-1:0]        prod;
    logic [DATA_W-1:0]        hi;
    logic                     accept, wb_en;
    logic [IDX_W-1:0]         ra_idx;

    // Operand index decode from the incoming instruction
    always_comb begin
        ra_idx     = instr_i[RA_LSB +: IDX_W];
        rd_addr[0] = instr_i[RM_LSB +: IDX_W];
        rd_addr[1] = instr_i[RN_LSB +: IDX_W];
        rd_addr[2] = ra_idx;
        accept     = start_i && (state == ST_IDLE);
        wb_en      = (state == ST_CMB);
        busy_o     = (state != ST_IDLE);
    end

    mmw_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT), .NRD(NRD)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wb_en   (wb_en),
        .wb_addr (ctrl_q.dst),
        .wb_data (hi),
        .tw_en   (tb_we_i),
        .tw_addr (tb_waddr_i),
        .tw_data (tb_wdata_i),
        .tr_addr (tb_raddr_i),
        .tr_data (tb_rdata_o)
    );

    // Sequencer: idle -> multiply -> combine/write-back -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) state <= ST_MUL;
                ST_MUL:  state <= ST_CMB;
                ST_CMB:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Operand and control capture on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            op_a_q <= '0;
            op_b_q <= '0;
            acc_q  <= '0;
        end else if (accept) begin
            ctrl_q.dst    <= instr_i[RD_LSB +: IDX_W];
            ctrl_q.acc_en <= (ra_idx != NO_ACC_IDX);
            ctrl_q.sub    <= instr_i[SUB_BIT];
            ctrl_q.rnd    <= instr_i[RND_BIT];
            op_a_q        <= rd_data[0];
            op_b_q        <= rd_data[1];
            acc_q         <= rd_data[2];
        end
    end

    mmw_mul_stage #(.DATA_W(DATA_W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_MUL),
        .op_a  (op_a_q),
        .op_b  (op_b_q),
        .prod  (prod)
    );

    mmw_combine #(.DATA_W(DATA_W)) u_cmb (
        .prod   (prod),
        .acc    (acc_q),
        .acc_en (ctrl_q.acc_en),
        .sub    (ctrl_q.sub),
        .rnd    (ctrl_q.rnd),
        .hi     (hi)
    );

    // Completion pulse one cycle after write-back
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= wb_en;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_AFTER_CMB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMB) |=> done_o); // R8
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R9
    AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !done_o || $past(state == ST_IDLE) == 1'b0); // R9
endmodule

// File: tb/mmw_exec_unit_tb.sv
// Directed bench for mmw_exec_unit: one task per scenario, each checking its results.
module mmw_exec_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic        busy_o, done_o;
    logic        tb_we_i = 1'b0;
    logic [3:0]  tb_waddr_i = '0;
    logic [31:0] tb_wdata_i = '0;
    logic [3:0]  tb_raddr_i = '0;
    logic [31:0] tb_rdata_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmw_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .busy_o(busy_o), .done_o(done_o),
        .tb_we_i(tb_we_i), .tb_waddr_i(tb_waddr_i), .tb_wdata_i(tb_wdata_i),
        .tb_raddr_i(tb_raddr_i), .tb_rdata_o(tb_rdata_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Instruction builder: rd 19:16, ra 15:12, rm 11:8, sub bit 6, rnd bit 5, rn 3:0
    function automatic logic [31:0] mk(input logic [3:0] rd, ra, rm, rn, input logic sub, rnd);
        return {12'h000, rd, ra, rm, 1'b0, sub, rnd, 1'b0, rn};
    endfunction

    // Expected high word from the requirement formulas
    function automatic logic [31:0] model(input logic [31:0] a, b, acc, input logic en, sub, rnd);
        logic [63:0] p, s;
        p = 64'($signed(a)) * 64'($signed(b));
        if (!en)      s = p;
        else if (sub) s = {acc, 32'h0} - p;
        else          s = {acc, 32'h0} + p;
        if (rnd) s = s + 64'h8000_0000;
        return s[63:32];
    endfunction

    task automatic wr(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        tb_we_i = 1'b1; tb_waddr_i = idx; tb_wdata_i = val;
        @(negedge clk);
        tb_we_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] val);
        tb_raddr_i = idx;
        #1;
        val = tb_rdata_o;
    endtask

    // Launch one op and check the R8 latency profile; returns at the done cycle
    task automatic run_op(input logic [31:0] ins);
        @(negedge clk);
        instr_i = ins; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !done_o, "R8 busy after start", {30'd0, busy_o, done_o}, 32'h2);
        @(negedge clk);
        check(!done_o, "R8 no early done", {31'd0, done_o}, 32'h0);
        @(negedge clk);
        check(done_o, "R8 done pulse", {31'd0, done_o}, 32'h1);
    endtask

    task automatic op_check(input string req, input logic [3:0] d, ra, rm, rn, input logic sub, rnd, input logic [31:0] exp);
        logic [31:0] got;
        run_op(mk(d, ra, rm, rn, sub, rnd));
        rd(d, got);
        check(got == exp, req, got, exp);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check(!busy_o && !done_o, "R1 idle after reset", {30'd0, busy_o, done_o}, 32'h0);
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), v);
            check(v == 32'h0, "R1 register cleared", v, 32'h0);
        end
    endtask

    task automatic t_plain();
        wr(4'd1, 32'h1234_5678); wr(4'd2, 32'h9ABC_DEF0);
        op_check("R3 plain mixed sign", 4'd3, 4'd15, 4'd1, 4'd2, 1'b0, 1'b0,
                 model(32'h1234_5678, 32'h9ABC_DEF0, 32'h0, 1'b0, 1'b0, 1'b0));
        wr(4'd8, 32'h8000_0000); wr(4'd9, 32'h8000_0000);
        op_check("R3 min times min", 4'd10, 4'd15, 4'd8, 4'd9, 1'b0, 1'b0, 32'h4000_0000);
        // R2: operand fields distinct; rm=8 (min), rn=2 (neg), other regs hold other values
        op_check("R2 field positions", 4'd11, 4'd15, 4'd8, 4'd2, 1'b0, 1'b0,
                 model(32'h8000_0000, 32'h9ABC_DEF0, 32'h0, 1'b0, 1'b0, 1'b0));
    endtask

    task automatic t_plain_bit6();
        op_check("R11 bit6 ignored without accumulator", 4'd12, 4'd15, 4'd1, 4'd2, 1'b1, 1'b0,
                 model(32'h1234_5678, 32'h9ABC_DEF0, 32'h0, 1'b0, 1'b0, 1'b0));
    endtask

    task automatic t_acc();
        wr(4'd4, 32'h0000_1000);
        op_check("R4 accumulate", 4'd5, 4'd4, 4'd1, 4'd2, 1'b0, 1'b0,
                 model(32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_1000, 1'b1, 1'b0, 1'b0));
    endtask

    task automatic t_sub();
        op_check("R5 accumulator minus product", 4'd6, 4'd4, 4'd1, 4'd2, 1'b1, 1'b0,
                 model(32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_1000, 1'b1, 1'b1, 1'b0));
    endtask

    task automatic t_round();
        wr(4'd1, 32'h0001_0000); wr(4'd2, 32'h0000_8000);
        op_check("R6 truncate half", 4'd3, 4'd15, 4'd1, 4'd2, 1'b0, 1'b0, 32'h0000_0000);
        op_check("R6 round half up", 4'd3, 4'd15, 4'd1, 4'd2, 1'b0, 1'b1, 32'h0000_0001);
        op_check("R6 round with subtract", 4'd7, 4'd4, 4'd1, 4'd2, 1'b1, 1'b1,
                 model(32'h0001_0000, 32'h0000_8000, 32'h0000_1000, 1'b1, 1'b1, 1'b1));
    endtask

    task automatic t_wrap();
        wr(4'd1, 32'h7FFF_FFFF); wr(4'd2, 32'h7FFF_FFFF); wr(4'd4, 32'h7FFF_FFFF);
        op_check("R7 wrap on accumulate", 4'd5, 4'd4, 4'd1, 4'd2, 1'b0, 1'b0, 32'hBFFF_FFFE);
        wr(4'd4, 32'h8000_0000);
        op_check("R7 wrap on subtract", 4'd5, 4'd4, 4'd1, 4'd2, 1'b1, 1'b0,
                 model(32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b1, 1'b0));
    endtask

    task automatic t_alias();
        wr(4'd4, 32'h0000_0300); wr(4'd5, 32'hFFFF_0000);
        // rd = rm = ra = 4: old value 0x300 used for every source
        op_check("R10 destination aliases sources", 4'd4, 4'd4, 4'd4, 4'd5, 1'b0, 1'b1,
                 model(32'h0000_0300, 32'hFFFF_0000, 32'h0000_0300, 1'b1, 1'b0, 1'b1));
    endtask

    task automatic t_busy();
        logic [31:0] v;
        wr(4'd1, 32'h0000_0002); wr(4'd2, 32'h0000_0003); wr(4'd13, 32'hDEAD_BEEF);
        @(negedge clk);
        instr_i = mk(4'd14, 4'd15, 4'd1, 4'd2, 1'b0, 1'b0); start_i = 1'b1;
        @(negedge clk);
        instr_i = mk(4'd13, 4'd15, 4'd1, 4'd2, 1'b0, 1'b0); // start while busy
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check(done_o, "R9 first op completes", {31'd0, done_o}, 32'h1);
        @(negedge clk);
        check(!done_o && !busy_o, "R9 no second done", {30'd0, busy_o, done_o}, 32'h0);
        @(negedge clk);
        check(!done_o && !busy_o, "R9 still idle", {30'd0, busy_o, done_o}, 32'h0);
        rd(4'd13, v);
        check(v == 32'hDEAD_BEEF, "R9 ignored start wrote nothing", v, 32'hDEAD_BEEF);
        rd(4'd14, v);
        check(v == 32'h0, "R9 first op high word", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_plain_bit6();
        t_acc();
        t_sub();
        t_round();
        t_wrap();
        t_alias();
        t_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule